// File: doc/BRIEF.md
# Trap Entry State Sequencer

This block carries out the architectural state change that a register-window processor makes when it takes a trap. A one-cycle `trap_valid` strobe brings in an 8-bit trap type, the current and next fetch addresses, the status fields (trap enable, supervisor, previous supervisor, window pointer) and the trap base register. One clock later the block presents the updated status, the decremented window pointer, two write-enabled save words for the new window's locals, and the vector fetch addresses. A `done` pulse marks a trap that was vectored.

If traps are disabled when a trap arrives, the processor does not vector. It enters a sticky error state instead. The one exception is the shutdown trap type when the shutdown strap is set: that case raises a shutdown request. A floating-point exception trap first fills a one-entry deferred queue, and only when the queue is empty. It then steps the fetch addresses forward by one instruction before the normal entry sequence runs.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, `done`, `error_state`, `shutdown_req`, `save_we_l1`, `save_we_l2` and `fpq_we` are all 0.
- R2: A `trap_valid` with `et_in`=1 while not in error state gives `done`=1 on the next cycle with `et_out`=0. Every output shown in R3 to R9 is registered and valid in that same cycle.
- R3: `cwp_out` equals `cwp_in` minus one. When `cwp_in` is 0 it wraps to NWIN-1.
- R4: `save_we_l1` and `save_we_l2` pulse together with `done`. `save_data_l1` carries the saved program counter, `save_data_l2` carries the saved next program counter, and `save_win` equals `cwp_out`.
- R5: `ps_out` takes the incoming `s_in`, and `s_out` is 1.
- R6: `tbr_out` keeps `tbr_in[31:12]`, places the trap type in bits 11:4, and has bits 3:0 zero.
- R7: `pc_out` equals `tbr_out`, and `npc_out` equals `tbr_out + 4`.
- R8: For trap type 0x08 (floating-point exception), the saved program counter is `npc_in` and the saved next program counter is `npc_in + 4`. For every other type, the saved values are `pc_in` and `npc_in`.
- R9: For trap type 0x08 with `fpq_ne_in`=0, `fpq_we` pulses with `fpq_addr`=`pc_in` and `fpq_insn`=`fetch_word`. With `fpq_ne_in`=1 there is no fill. `fpq_ne_out` is 1 after any type 0x08 trap and otherwise equals `fpq_ne_in`.
- R10: A `trap_valid` with `et_in`=0, other than the R11 case, sets `error_state`. The error state holds until reset and produces no `done`. Any later `trap_valid` is ignored, so no `done` follows.
- R11: Trap type 0x80 with `et_in`=0 and `shutdown_en`=1 pulses `shutdown_req` for one cycle. It does not set `error_state` and gives no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trap_valid | input | 1 | Trap request strobe |
| trap_type | input | 8 | Trap type |
| pc_in | input | 32 | Current program counter |
| npc_in | input | 32 | Next program counter |
| et_in | input | 1 | Trap enable |
| s_in | input | 1 | Supervisor bit |
| ps_in | input | 1 | Previous supervisor bit |
| cwp_in | input | CW | Current window pointer |
| tbr_in | input | 32 | Trap base register |
| shutdown_en | input | 1 | Shutdown strap |
| fpq_ne_in | input | 1 | Deferred FP queue occupied |
| fetch_word | input | 32 | Instruction word at `pc_in` |
| done | output | 1 | Trap vectored pulse |
| error_state | output | 1 | Sticky error state |
| shutdown_req | output | 1 | Shutdown request pulse |
| et_out | output | 1 | Updated trap enable |
| s_out | output | 1 | Updated supervisor |
| ps_out | output | 1 | Updated previous supervisor |
| cwp_out | output | CW | Updated window pointer |
| tbr_out | output | 32 | Updated trap base register |
| pc_out | output | 32 | Vector fetch address |
| npc_out | output | 32 | Vector next fetch address |
| save_we_l1 | output | 1 | Write enable, local 1 |
| save_we_l2 | output | 1 | Write enable, local 2 |
| save_win | output | CW | Window for the saves |
| save_data_l1 | output | 32 | Saved program counter |
| save_data_l2 | output | 32 | Saved next program counter |
| fpq_we | output | 1 | FP queue fill pulse |
| fpq_ne_out | output | 1 | Updated FP queue flag |
| fpq_addr | output | 32 | FP queue address |
| fpq_insn | output | 32 | FP queue instruction |

## Verification
The assertions check on every cycle that:
- a vectored trap clears trap enable, sets supervisor, aligns the vector, keeps the window pointer in range, and pulses its save enables with `done`;
- the error state is sticky;
- a shutdown never coincides with `done`;
- every enabled trap yields `done` one cycle later.

Only the bench sweep can show the exact arithmetic, because it computes the expected values itself. That covers the vector address built from the trap type, the saved addresses with and without the floating-point adjustment, the window wrap from zero, and the queue fill that depends on the prior queue flag. It also covers the scenario sequences: error then an ignored trap, and the shutdown strap on and off.

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
  parameter int NWIN = 8,
  parameter logic [7:0] FP_TT = 8'h08,
  parameter logic [7:0] SHUT_TT = 8'h80,
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trap_valid,
  input  logic [7:0]    trap_type,
  input  logic [31:0]   pc_in,
  input  logic [31:0]   npc_in,
  input  logic          et_in,
  input  logic          s_in,
  input  logic          ps_in,
  input  logic [CW-1:0] cwp_in,
  input  logic [31:0]   tbr_in,
  input  logic          shutdown_en,
  input  logic          fpq_ne_in,
  input  logic [31:0]   fetch_word,
  output logic          done,
  output logic          error_state,
  output logic          shutdown_req,
  output logic          et_out,
  output logic          s_out,
  output logic          ps_out,
  output logic [CW-1:0] cwp_out,
  output logic [31:0]   tbr_out,
  output logic [31:0]   pc_out,
  output logic [31:0]   npc_out,
  output logic          save_we_l1,
  output logic          save_we_l2,
  output logic [CW-1:0] save_win,
  output logic [31:0]   save_data_l1,
  output logic [31:0]   save_data_l2,
  output logic          fpq_we,
  output logic          fpq_ne_out,
  output logic [31:0]   fpq_addr,
  output logic [31:0]   fpq_insn
);
  localparam logic [CW-1:0] TOP_WIN = CW'(NWIN - 1);

  logic live, take, halt, is_shut, is_fp;
  logic [31:0] pc_sv, npc_sv, tbr_nx;
  logic [CW-1:0] cwp_nx;

  assign live    = trap_valid && !error_state;
  assign take    = live && et_in;
  assign halt    = live && !et_in;
  assign is_shut = (trap_type == SHUT_TT) && shutdown_en;
  assign is_fp   = (trap_type == FP_TT);
  assign pc_sv   = is_fp ? npc_in : pc_in;
  assign npc_sv  = is_fp ? npc_in + 32'd4 : npc_in;
  assign tbr_nx  = {tbr_in[31:12], trap_type, 4'b0000};
  assign cwp_nx  = (cwp_in == '0) ? TOP_WIN : cwp_in - 1'b1;

  assign pc_out     = tbr_out;
  assign npc_out    = tbr_out + 32'd4;
  assign save_win   = cwp_out;
  assign save_we_l2 = save_we_l1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done         <= 1'b0;
      error_state  <= 1'b0;
      shutdown_req <= 1'b0;
      save_we_l1   <= 1'b0;
      fpq_we       <= 1'b0;
      et_out       <= 1'b0;
      s_out        <= 1'b1;
      ps_out       <= 1'b0;
      cwp_out      <= '0;
      tbr_out      <= '0;
      save_data_l1 <= '0;
      save_data_l2 <= '0;
      fpq_ne_out   <= 1'b0;
      fpq_addr     <= '0;
      fpq_insn     <= '0;
    end else begin
      done         <= take;
      save_we_l1   <= take;
      shutdown_req <= halt && is_shut;
      fpq_we       <= take && is_fp && !fpq_ne_in;
      if (halt && !is_shut) error_state <= 1'b1;
      if (take) begin
        et_out       <= 1'b0;
        s_out        <= 1'b1;
        ps_out       <= s_in;
        cwp_out      <= cwp_nx;
        tbr_out      <= tbr_nx;
        save_data_l1 <= pc_sv;
        save_data_l2 <= npc_sv;
        fpq_ne_out   <= fpq_ne_in | is_fp;
        if (is_fp && !fpq_ne_in) begin
          fpq_addr <= pc_in;
          fpq_insn <= fetch_word;
        end
      end
    end
  end

  logic unused_ok;
  assign unused_ok = ps_in;
endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
  parameter int NWIN = 8,
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trap_valid,
  input logic          et_in,
  input logic          done,
  input logic          error_state,
  input logic          shutdown_req,
  input logic          et_out,
  input logic          s_out,
  input logic [CW-1:0] cwp_out,
  input logic [31:0]   pc_out,
  input logic [31:0]   npc_out,
  input logic          save_we_l1,
  input logic          save_we_l2
);
  assert_trap_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && et_in && !error_state |=> done);
  assert_et_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !et_out);
  assert_win_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(cwp_out) < NWIN));
  assert_save_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (save_we_l1 && save_we_l2));
  assert_super_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> s_out);
  assert_vec_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pc_out[3:0] == 4'h0 && npc_out == pc_out + 32'd4));
  assert_error_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    error_state |=> error_state);
  assert_error_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(error_state) |-> !done);
  assert_shutdown_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> !done);
endmodule

bind trap_entry_seq trap_entry_seq_chk #(.NWIN(NWIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .et_in(et_in),
  .done(done), .error_state(error_state), .shutdown_req(shutdown_req),
  .et_out(et_out), .s_out(s_out), .cwp_out(cwp_out), .pc_out(pc_out),
  .npc_out(npc_out), .save_we_l1(save_we_l1), .save_we_l2(save_we_l2));

// File: tb/test_trap_entry_seq.sv
`timescale 1ns/1ps
module test_trap_entry_seq;
  localparam int NWIN = 8;
  localparam int CW = 3;

  logic clk = 0, rst_n = 0, trap_valid = 0, et_in = 0, s_in = 0, ps_in = 0;
  logic shutdown_en = 0, fpq_ne_in = 0;
  logic [7:0] trap_type = '0;
  logic [31:0] pc_in = '0, npc_in = '0, tbr_in = '0, fetch_word = '0;
  logic [CW-1:0] cwp_in = '0;
  logic done, error_state, shutdown_req, et_out, s_out, ps_out;
  logic [CW-1:0] cwp_out, save_win;
  logic [31:0] tbr_out, pc_out, npc_out, save_data_l1, save_data_l2, fpq_addr, fpq_insn;
  logic save_we_l1, save_we_l2, fpq_we, fpq_ne_out;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  trap_entry_seq #(.NWIN(NWIN)) i_trap_entry_seq (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    trap_valid = 0;
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;
  endtask

  task automatic fire();
    trap_valid = 1;
    @(posedge clk);
    @(negedge clk) trap_valid = 0;
  endtask

  task automatic vec_check(input logic [7:0] tt, input logic [2:0] cw, input logic sv,
                           input logic [31:0] pc, input logic [31:0] tbr, input logic qne);
    logic fp;
    logic [31:0] etbr, epc, enpc;
    logic [2:0] ecwp;
    fp = (tt == 8'h08);
    trap_type = tt; cwp_in = cw; s_in = sv; ps_in = ~sv; et_in = 1;
    pc_in = pc; npc_in = pc + 4; tbr_in = tbr; fpq_ne_in = qne;
    fetch_word = ~pc;
    fire();
    etbr = {tbr[31:12], tt, 4'h0};
    ecwp = (cw == 0) ? 3'(NWIN - 1) : cw - 3'd1;
    epc  = fp ? pc + 4 : pc;
    enpc = fp ? pc + 8 : pc + 4;
    chk(done === 1'b1 && et_out === 1'b0, "R2", {done, et_out}, 2'b10);
    chk(cwp_out === ecwp, "R3", cwp_out, ecwp);
    chk(save_we_l1 && save_we_l2 && save_win === ecwp, "R4 we/win", save_win, ecwp);
    chk(save_data_l1 === epc, "R4/R8 l1", save_data_l1, epc);
    chk(save_data_l2 === enpc, "R4/R8 l2", save_data_l2, enpc);
    chk(s_out === 1'b1 && ps_out === sv, "R5", {s_out, ps_out}, {1'b1, sv});
    chk(tbr_out === etbr, "R6", tbr_out, etbr);
    chk(pc_out === etbr && npc_out === etbr + 4, "R7", pc_out, etbr);
    chk(fpq_we === (fp && !qne), "R9 we", fpq_we, fp && !qne);
    chk(fpq_ne_out === (qne | fp), "R9 ne", fpq_ne_out, qne | fp);
    if (fp && !qne)
      chk(fpq_addr === pc && fpq_insn === ~pc, "R9 entry", fpq_addr, pc);
  endtask

  initial begin
    #900000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk(!done && !error_state && !shutdown_req && !save_we_l1 && !save_we_l2 && !fpq_we,
        "R1", {done, error_state, shutdown_req, save_we_l1, fpq_we}, 0);

    for (int t = 0; t < 256; t++)
      vec_check(8'(t), 3'(t % 8), t[0], 32'h1000_0000 + 32'(t * 8),
                32'hABCD_EFFF ^ (32'(t) << 12), t[1]);
    vec_check(8'h08, 3'd0, 1'b1, 32'h2000_0040, 32'h5555_5000, 1'b1);
    vec_check(8'h08, 3'd5, 1'b0, 32'h3000_0100, 32'h0000_1ABC, 1'b0);
    @(negedge clk);
    chk(!done && !save_we_l1 && !fpq_we, "R2 pulse", {done, save_we_l1, fpq_we}, 0);

    shutdown_en = 1;
    vec_check(8'h80, 3'd2, 1'b0, 32'h4000_0000, 32'hFFFF_F000, 1'b0);

    do_reset();
    shutdown_en = 1; et_in = 0; trap_type = 8'h80;
    fire();
    chk(shutdown_req === 1'b1 && !error_state && !done, "R11",
        {shutdown_req, error_state, done}, 3'b100);
    @(negedge clk);
    chk(shutdown_req === 1'b0, "R11 pulse", shutdown_req, 0);

    do_reset();
    shutdown_en = 0; et_in = 0; trap_type = 8'h80;
    fire();
    chk(error_state === 1'b1 && !shutdown_req && !done, "R10 strap off",
        {error_state, shutdown_req, done}, 3'b100);

    do_reset();
    shutdown_en = 1; et_in = 0; trap_type = 8'h05;
    fire();
    chk(error_state === 1'b1 && !done && !save_we_l1, "R10 set",
        {error_state, done}, 2'b10);
    et_in = 1; trap_type = 8'h11;
    fire();
    chk(error_state === 1'b1 && !done && !save_we_l1, "R10 ignored",
        {error_state, done}, 2'b10);
    repeat (3) @(negedge clk);
    chk(error_state === 1'b1, "R10 sticky", error_state, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule